// File: doc/BRIEF.md
# GPS-Aligned One-Pulse-Per-Second Generator

This block produces a local once-per-second pulse whose rising edge is placed on the rising edge of an external GPS second pulse. It runs on a fast clock, the oscillator divided down to roughly 1.15 GHz in the target system. It takes two asynchronous inputs: a 10 MHz reference and the GPS pulse. Both are brought into the fast-clock domain and turned into single-cycle edge events.

Alignment works in two stages. First, a reference-edge counter that divides down to 1 Hz is re-phased from the GPS edge. This places the local coarse edge up to one reference period ahead of the next GPS edge. Second, a delay counted in fast-clock cycles shifts the coarse edge onto the GPS edge. The delay value is the number of fast cycles measured between the coarse edge and the GPS edge in the previous second. A final stage sets the pulse width to a fixed number of reference periods. A lock flag reports when the remaining error has stayed within one fast cycle for two seconds in a row.

Top module: `pps_gps_align`

## Requirements
- R1: While reset is applied and afterwards, `pps_out` and `locked` stay low. No pulse appears until the divider has been phased from a GPS edge and a full second has elapsed.
- R2: The first pulse after acquisition leads the aligned position by P fast-clock cycles. P is the GPS edge position within a reference period, and P is in 0 to REF_PER-1.
- R3: From the second pulse on, with a steady GPS input, `pps_out` rises on the third rising clock edge after the rising edge of `gps_in`. The fine delay applied is always in 0..FINE_MAX.
- R4: Consecutive pulses are REF_PER_SEC reference periods apart.
- R5: Each pulse is high for more than WIDTH_REF-1 and at most WIDTH_REF reference periods.
- R6: `locked` rises after the residual error has been at most one fast cycle on two consecutive GPS edges, and not earlier.
- R7: If no GPS edge arrives within FINE_MAX fast cycles after a coarse edge, `locked` drops. Pulses continue with unchanged period and delay, and lock returns after two good seconds.
- R8: After a GPS phase step, one pulse rises off by the old delay error. Pulses are aligned again from the second GPS edge after the step, and `locked` is low after the first such edge and high again after the third.
- R9: When the GPS edge falls on the same fast cycle as a reference edge, the first pulse is already aligned and `locked` rises after the second GPS edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (oscillator divided by four) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Asynchronous reference clock, 10 MHz nominal |
| gps_in | input | 1 | Asynchronous GPS second pulse |
| pps_out | output | 1 | Aligned second pulse with trimmed width |
| locked | output | 1 | Residual error within one fast cycle for two seconds |

## Verification
The main alignment is tried with GPS edges at two sub-reference phases. An offset of five fast cycles separates the coarse stage (first pulse early by exactly that amount) from the fine stage (aligned afterwards). A zero offset exercises the case where the GPS and reference edges coincide. A dropped GPS second shows that the free-running divider keeps period and delay while the lock flag falls. A large forward phase step shows the one-second transient that comes from the stale fine delay, followed by relock. Pulse width and period are measured on pulses that arrive with different delays.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  // synchronizer depth ahead of the edge detector
  localparam int SYNC_DEPTH = 2;
  // residual error accepted as good, in fast cycles
  localparam int GOOD_TOL = 1;
  // consecutive good seconds needed for lock
  localparam int LOCK_RUN = 2;

  typedef struct packed {
    logic ref_rise;
    logic gps_rise;
  } edge_ev_t;
endpackage

// File: rtl/pps_sync.sv
`timescale 1ns/1ps
module pps_sync #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] async_in,
  output logic [NBITS-1:0] rise
);
  import pps_pkg::*;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [SYNC_DEPTH-1:0] chain_q;
    logic [SYNC_DEPTH-1:0] chain_n;
    logic                  prev_q;

    always_comb begin
      chain_n = {chain_q[SYNC_DEPTH-2:0], async_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_n;
        prev_q  <= chain_q[SYNC_DEPTH-1];
      end
    end

    assign rise[b] = chain_q[SYNC_DEPTH-1] & ~prev_q;

    // R3: every synchronized edge is a single-cycle event
    p_single_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise[b] |=> !rise[b]);
  end
endmodule

// File: rtl/pps_coarse_div.sv
`timescale 1ns/1ps
module pps_coarse_div #(
  parameter int REF_PER_SEC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic gps_tick,
  output logic coarse_edge,
  output logic aligned
);
  localparam int CW = $clog2(REF_PER_SEC);
  localparam logic [CW-1:0] CNT_LAST = CW'(REF_PER_SEC - 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n;
  logic          algn_q, algn_n;
  logic          load;

  always_comb begin
    // re-phase on the first reference edge strictly after a GPS edge
    load        = pend_q & ref_tick;
    coarse_edge = algn_q & ref_tick & ~load & (cnt_q == CNT_LAST);
    pend_n      = pend_q;
    if (load)     pend_n = 1'b0;
    if (gps_tick) pend_n = 1'b1;
    algn_n = algn_q | load;
    cnt_n  = cnt_q;
    if (load)
      cnt_n = CNT_LOAD;
    else if (algn_q && ref_tick)
      cnt_n = (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      algn_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      algn_q <= algn_n;
    end
  end

  assign aligned = algn_q;

  // R4: divider count stays inside one second
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R2: divider only re-phases after a GPS edge was seen
  p_load_follows_gps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(algn_q) |-> $past(pend_q));
endmodule

// File: rtl/pps_fine_meas.sv
`timescale 1ns/1ps
module pps_fine_meas #(
  parameter int FINE_MAX = 114
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              coarse_edge,
  input  logic                              gps_tick,
  output logic [$clog2(FINE_MAX+1)-1:0]     fine_dly,
  output logic                              locked
);
  import pps_pkg::*;

  localparam int FW = $clog2(FINE_MAX + 1);
  localparam int MW = $clog2(FINE_MAX + 2);
  localparam logic [MW-1:0] MEAS_TOP = MW'(FINE_MAX);

  logic          win_q, win_n;
  logic [MW-1:0] meas_q, meas_n;
  logic [FW-1:0] fine_q, fine_n;
  logic [1:0]    run_q, run_n;
  logic          lock_q, lock_n;
  logic          capture, miss, good, bad;
  logic [FW-1:0] err_now;
  int            diff;

  always_comb begin
    capture = gps_tick & (win_q | coarse_edge);
    err_now = coarse_edge ? '0 : meas_q[FW-1:0];
    miss    = win_q & ~gps_tick & (meas_q == MEAS_TOP);
    diff    = int'(err_now) - int'(fine_q);
    good    = capture && (diff >= -GOOD_TOL) && (diff <= GOOD_TOL);
    bad     = miss || (capture && !good);

    win_n = win_q;
    if (coarse_edge && !gps_tick) win_n = 1'b1;
    else if (capture || miss)     win_n = 1'b0;

    meas_n = meas_q;
    if (coarse_edge)  meas_n = MW'(1);
    else if (win_q)   meas_n = meas_q + MW'(1);

    fine_n = capture ? err_now : fine_q;

    run_n  = run_q;
    lock_n = lock_q;
    if (bad) begin
      run_n  = '0;
      lock_n = 1'b0;
    end else if (good) begin
      run_n  = (int'(run_q) >= LOCK_RUN) ? run_q : run_q + 2'd1;
      lock_n = (int'(run_q) + 1 >= LOCK_RUN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      meas_q <= '0;
      fine_q <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      win_q  <= win_n;
      meas_q <= meas_n;
      fine_q <= fine_n;
      run_q  <= run_n;
      lock_q <= lock_n;
    end
  end

  assign fine_dly = fine_q;
  assign locked   = lock_q;

  // R3: applied delay never exceeds the covered range
  p_fine_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fine_q) <= FINE_MAX);
  // R6: lock only rises right after a good measurement
  p_lock_after_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(good));
  // R7: a window that expires without a GPS edge clears lock
  p_miss_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !lock_q);
endmodule

// File: rtl/pps_shaper.sv
`timescale 1ns/1ps
module pps_shaper #(
  parameter int FINE_MAX  = 114,
  parameter int WIDTH_REF = 4000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          coarse_edge,
  input  logic [$clog2(FINE_MAX+1)-1:0] fine_dly,
  input  logic                          ref_tick,
  output logic                          pulse
);
  localparam int FW = $clog2(FINE_MAX + 1);
  localparam int WW = $clog2(WIDTH_REF);
  localparam logic [WW-1:0] W_LAST = WW'(WIDTH_REF - 1);

  logic [FW-1:0] dcnt_q, dcnt_n;
  logic          dact_q, dact_n;
  logic [WW-1:0] wcnt_q, wcnt_n;
  logic          pulse_q, pulse_n;
  logic          start, w_end;

  always_comb begin
    start = (coarse_edge && (fine_dly == '0)) ||
            (dact_q && (dcnt_q == FW'(1)));
    dact_n = dact_q;
    if (coarse_edge && (fine_dly != '0)) dact_n = 1'b1;
    else if (start)                      dact_n = 1'b0;
    dcnt_n = dcnt_q;
    if (coarse_edge)  dcnt_n = fine_dly;
    else if (dact_q)  dcnt_n = dcnt_q - FW'(1);

    w_end   = pulse_q & ref_tick & (wcnt_q == W_LAST);
    pulse_n = pulse_q;
    wcnt_n  = wcnt_q;
    if (start) begin
      pulse_n = 1'b1;
      wcnt_n  = '0;
    end else if (pulse_q && ref_tick) begin
      wcnt_n = wcnt_q + WW'(1);
      if (w_end) pulse_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      dact_q  <= 1'b0;
      wcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      dcnt_q  <= dcnt_n;
      dact_q  <= dact_n;
      wcnt_q  <= wcnt_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse = pulse_q;

  // R5: width counter bounded while the pulse is high
  p_width_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (wcnt_q <= W_LAST));
  // R5: the pulse only ends on a reference edge
  p_fall_on_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> $past(ref_tick));
endmodule

// File: rtl/pps_gps_align.sv
`timescale 1ns/1ps
module pps_gps_align #(
  parameter int REF_PER_SEC = 10_000_000,
  parameter int FINE_MAX    = 114,
  parameter int WIDTH_REF   = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic gps_in,
  output logic pps_out,
  output logic locked
);
  import pps_pkg::*;

  localparam int FW = $clog2(FINE_MAX + 1);

  logic          rs1_q, rs2_q;
  logic          rst_sync_n;
  logic [1:0]    rise_vec;
  edge_ev_t      ev;
  logic          coarse_edge, aligned;
  logic [FW-1:0] fine_dly;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  pps_sync #(.NBITS(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in ({ref_in, gps_in}),
    .rise     (rise_vec)
  );
  assign ev = edge_ev_t'(rise_vec);

  pps_coarse_div #(.REF_PER_SEC(REF_PER_SEC)) u_coarse (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ref_tick    (ev.ref_rise),
    .gps_tick    (ev.gps_rise),
    .coarse_edge (coarse_edge),
    .aligned     (aligned)
  );

  pps_fine_meas #(.FINE_MAX(FINE_MAX)) u_meas (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .coarse_edge (coarse_edge),
    .gps_tick    (ev.gps_rise),
    .fine_dly    (fine_dly),
    .locked      (locked)
  );

  pps_shaper #(.FINE_MAX(FINE_MAX), .WIDTH_REF(WIDTH_REF)) u_shape (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .coarse_edge (coarse_edge),
    .fine_dly    (fine_dly),
    .ref_tick    (ev.ref_rise),
    .pulse       (pps_out)
  );

  // R1: nothing leaves the block before the divider is phased
  p_quiet_until_phased_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !aligned |-> !pps_out);
  // R6: lock implies the divider has been phased
  p_lock_needs_phase_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |-> aligned);
endmodule

// File: tb/test_pps_gps_align.sv
`timescale 1ns/1ps
module test_pps_gps_align;
  localparam int N_SEC   = 20;
  localparam int R_CYC   = 8;
  localparam int FMAX    = 7;
  localparam int W_REF   = 3;
  localparam int SEC     = N_SEC * R_CYC;
  localparam int LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic gps_in = 1'b0;
  logic pps_out, locked;

  int cyc = 0;
  int gps_off = 0;
  bit gps_en = 0;
  int gps_cyc [0:63];
  int gps_n = 0;
  int last_rise = -1000;
  int last_width = 0;
  int rise_n = 0;
  bit pps_prev = 0;
  bit locked_s = 0;
  bit pps_s = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  pps_gps_align #(.REF_PER_SEC(N_SEC), .FINE_MAX(FMAX), .WIDTH_REF(W_REF)) i_pps_gps_align (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .gps_in(gps_in),
    .pps_out(pps_out), .locked(locked));

  always #5 clk = ~clk;

  // stimulus and monitor, both at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      pps_s    = pps_out;
      locked_s = locked;
      if (pps_out && !pps_prev) begin
        last_rise = cyc;
        rise_n++;
      end
      if (!pps_out && pps_prev) last_width = cyc - last_rise;
      pps_prev = pps_out;
      begin
        int ph;
        bit g_new;
        ph    = ((cyc - gps_off) % SEC + SEC) % SEC;
        g_new = gps_en && (ph < 4);
        if (g_new && !gps_in) begin
          gps_cyc[gps_n % 64] = cyc;
          gps_n++;
        end
        gps_in = g_new;
      end
      ref_in = (cyc % R_CYC) < (R_CYC / 2);
      cyc++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
  endtask

  task automatic wait_gps(input int k);
    while (gps_n <= k) @(posedge clk);
  endtask

  // pulse belonging to GPS edge k rises at edge + 3 - lead
  task automatic chk_rise(input int k, input int lead, input string req);
    int g;
    wait_gps(k);
    g = gps_cyc[k % 64];
    wait_until(g + 10);
    check(last_rise == g + 3 - lead, req, last_rise - g, 3 - lead);
  endtask

  task automatic chk_width(input string req);
    wait_until(last_rise + W_REF * R_CYC + 4);
    check(last_width > (W_REF - 1) * R_CYC && last_width <= W_REF * R_CYC,
          req, last_width, W_REF * R_CYC);
  endtask

  task automatic t_reset();
    gps_en = 0;
    rst_n  = 1'b0;
    repeat (6) @(posedge clk);
    check(pps_s == 0, "R1 pps in reset", pps_s, 0);
    check(locked_s == 0, "R1 locked in reset", locked_s, 0);
    rst_n = 1'b1;
    begin
      int r0;
      r0 = rise_n;
      wait_until(cyc + 2 * SEC);
      check(rise_n == r0, "R1 no pulse without GPS", rise_n - r0, 0);
    end
  endtask

  task automatic t_acquire(input int ph, input string req_first);
    int k0, r_a;
    gps_off = ((cyc + 40) / R_CYC) * R_CYC + ph;
    gps_en  = 1;
    k0 = gps_n;
    chk_rise(k0 + 1, ph, req_first);
    chk_width("R5 width first pulse");
    chk_rise(k0 + 2, 0, "R3 aligned second pulse");
    check(locked_s == (ph <= 1), "R6 lock after two edges", locked_s, ph <= 1);
    r_a = last_rise;
    chk_rise(k0 + 3, 0, "R3 aligned third pulse");
    check(last_rise - r_a == SEC, "R4 period", last_rise - r_a, SEC);
    check(locked_s == 1, "R6 lock after three edges", locked_s, 1);
    chk_width("R5 width aligned pulse");
  endtask

  task automatic t_loss();
    int r_prev, k;
    gps_en = 0;
    r_prev = last_rise;
    wait_until(r_prev + SEC + 10);
    check(last_rise == r_prev + SEC, "R7 period kept without GPS", last_rise - r_prev, SEC);
    check(locked_s == 0, "R7 lock dropped", locked_s, 0);
    gps_en = 1;
    k = gps_n;
    chk_rise(k, 0, "R7 delay kept across gap");
    chk_rise(k + 1, 0, "R7 aligned after return");
    check(locked_s == 1, "R7 relock", locked_s, 1);
  endtask

  task automatic t_jump();
    int k;
    gps_off = gps_off + 37;
    k = gps_n;
    chk_rise(k + 1, -3, "R8 transient pulse");
    check(locked_s == 0, "R8 unlocked after step", locked_s, 0);
    chk_rise(k + 2, 0, "R8 realigned");
    chk_rise(k + 3, 0, "R8 stays aligned");
    check(locked_s == 1, "R8 relocked", locked_s, 1);
  endtask

  initial begin
    t_reset();
    t_acquire(5, "R2 first pulse early by phase");
    t_loss();
    t_jump();
    t_reset();
    t_acquire(0, "R9 coincident edges aligned at once");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule